// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block is a fully associative translation buffer that maps 40-bit virtual addresses onto 40-bit physical addresses with a fixed 16 KB page. Each of its 64 slots holds one tag that covers an aligned pair of neighbouring virtual pages. It also holds two physical frame numbers, one for the even page of the pair and one for the odd page, and each of those has its own valid flag. A single tag comparison therefore resolves either page of the pair. The lowest bit of the virtual page number chooses which frame is used.

Lookup is purely combinational: the caller presents an address with a request strobe and sees hit, miss and the translated address in the same cycle. A miss tells the refill handler to load the slot. Refill goes through a write port that replaces one whole slot at a given index on the next clock edge. A flush input empties every slot at once.

Top module: `pair_tlb`

## Requirements
- R1: The virtual address splits as offset = bits [13:0], pair tag = bits [39:15], and bit 14 selects the half (0 = even frame, 1 = odd frame).
- R2: With lk_req_i high, a slot whose tag equals the pair tag and whose selected half is valid gives lk_hit_o = 1, lk_miss_o = 0 and lk_paddr_o = {selected frame, bits [13:0] of the virtual address}.
- R3: With lk_req_i high and no usable translation, lk_miss_o = 1, lk_hit_o = 0 and lk_paddr_o = 0.
- R4: With lk_req_i low, lk_hit_o and lk_miss_o are both 0 and lk_paddr_o = 0.
- R5: When the winning slot's tag matches but its selected half is invalid, the lookup is a miss, even if the other half is valid.
- R6: A slot takes part in matching only if at least one of its halves is valid. Among several such slots with the same tag, the one with the lowest index decides the result.
- R7: A write changes nothing until the next rising clock edge. A lookup in the same cycle as the write sees the old contents, and a lookup in the cycle after it sees the new contents.
- R8: A write to an index replaces that slot's tag, both frames and both valid flags together.
- R9: A flush clears every valid flag at the next edge. A write in the same cycle as a flush is discarded.
- R10: After reset every slot is invalid, so every requested lookup misses.
- R11: All 64 indices (0 to 63) can be written separately, and each one translates its own pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate every slot |
| lk_req_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 40 | Virtual address to translate |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | Requested lookup found no translation |
| lk_paddr_o | output | 40 | Physical address, zero unless hit |
| wr_en_i | input | 1 | Write a slot |
| wr_idx_i | input | 6 | Slot index to write |
| wr_tag_i | input | 25 | Pair tag (virtual address bits [39:15]) |
| wr_pfn_even_i | input | 26 | Frame for the even page |
| wr_val_even_i | input | 1 | Even half valid |
| wr_pfn_odd_i | input | 26 | Frame for the odd page |
| wr_val_odd_i | input | 1 | Odd half valid |

## Verification
Random lookups draw their tags from a pool of four values, and random writes fill random slots from that same pool. This mixes hits, partial-half misses and duplicate tags in different slots, so the bench can tell apart correct half selection, correct lowest-index priority and a plain tag compare. Directed cases fill all 64 slots with distinct tags to expose index decoding faults. Two slots are stacked on one tag so that the lower slot has an invalid half, which separates "first tag match" from "first valid hit". Further cases overlap a write, and a flush with a write, with a lookup to pin down the one-edge update timing and the flush priority.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  parameter int unsigned TLB_SLOTS = 64;
  parameter int unsigned TLB_VA_W  = 40;
  parameter int unsigned TLB_PA_W  = 40;
  parameter int unsigned TLB_OFF_W = 14;
endpackage

// File: rtl/pair_tlb_store.sv
module pair_tlb_store #(
  parameter int unsigned SLOTS = 64,
  parameter int unsigned TAG_W = 25,
  parameter int unsigned PFN_W = 26,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic [PFN_W-1:0]            wr_pfn_e_i,
  input  logic                        wr_val_e_i,
  input  logic [PFN_W-1:0]            wr_pfn_o_i,
  input  logic                        wr_val_o_i,
  output logic [SLOTS-1:0][TAG_W-1:0] tag_o,
  output logic [SLOTS-1:0][PFN_W-1:0] pfn_e_o,
  output logic [SLOTS-1:0][PFN_W-1:0] pfn_o_o,
  output logic [SLOTS-1:0]            val_e_o,
  output logic [SLOTS-1:0]            val_o_o
);
  logic wr_go;
  assign wr_go = wr_en_i && !flush_i;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic sel;
    assign sel = wr_go && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_e_o[g] <= 1'b0;
        val_o_o[g] <= 1'b0;
      end else if (flush_i) begin
        val_e_o[g] <= 1'b0;
        val_o_o[g] <= 1'b0;
      end else if (sel) begin
        val_e_o[g] <= wr_val_e_i;
        val_o_o[g] <= wr_val_o_i;
      end
    end

    // payload needs no reset: always qualified by the valid flags
    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_o[g]   <= wr_tag_i;
        pfn_e_o[g] <= wr_pfn_e_i;
        pfn_o_o[g] <= wr_pfn_o_i;
      end
    end
  end
endmodule

// File: rtl/pair_tlb_cam.sv
module pair_tlb_cam #(
  parameter int unsigned SLOTS = 64,
  parameter int unsigned TAG_W = 25
) (
  input  logic [TAG_W-1:0]            look_tag_i,
  input  logic                        look_odd_i,
  input  logic [SLOTS-1:0][TAG_W-1:0] tag_i,
  input  logic [SLOTS-1:0]            val_e_i,
  input  logic [SLOTS-1:0]            val_o_i,
  output logic [SLOTS-1:0]            match_o,
  output logic [SLOTS-1:0]            half_ok_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    // a slot with both halves empty never competes
    assign match_o[g]   = (tag_i[g] == look_tag_i) && (val_e_i[g] || val_o_i[g]);
    assign half_ok_o[g] = look_odd_i ? val_o_i[g] : val_e_i[g];
  end
endmodule

// File: rtl/pair_tlb_pick.sv
module pair_tlb_pick #(
  parameter int unsigned SLOTS = 64,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int unsigned SLOTS = TLB_SLOTS,
  parameter int unsigned VA_W  = TLB_VA_W,
  parameter int unsigned PA_W  = TLB_PA_W,
  parameter int unsigned OFF_W = TLB_OFF_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      lk_req_i,
  input  logic [VA_W-1:0]           lk_vaddr_i,
  output logic                      lk_hit_o,
  output logic                      lk_miss_o,
  output logic [PA_W-1:0]           lk_paddr_o,
  input  logic                      wr_en_i,
  input  logic [$clog2(SLOTS)-1:0]  wr_idx_i,
  input  logic [VA_W-OFF_W-2:0]     wr_tag_i,
  input  logic [PA_W-OFF_W-1:0]     wr_pfn_even_i,
  input  logic                      wr_val_even_i,
  input  logic [PA_W-OFF_W-1:0]     wr_pfn_odd_i,
  input  logic                      wr_val_odd_i
);
  localparam int unsigned IDX_W = $clog2(SLOTS);
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned TAG_W = VPN_W - 1;
  localparam int unsigned PFN_W = PA_W - OFF_W;

  logic [SLOTS-1:0][TAG_W-1:0] tag_q;
  logic [SLOTS-1:0][PFN_W-1:0] pfn_e_q, pfn_o_q;
  logic [SLOTS-1:0]            val_e_q, val_o_q;
  logic [SLOTS-1:0]            match, half_ok;
  logic [IDX_W-1:0]            win_idx;
  logic                        win_any, hit_raw, look_odd;
  logic [TAG_W-1:0]            look_tag;
  logic [PFN_W-1:0]            pfn_sel;

  assign look_odd = lk_vaddr_i[OFF_W];
  assign look_tag = lk_vaddr_i[VA_W-1:OFF_W+1];

  pair_tlb_store #(.SLOTS(SLOTS), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_tag_i   (wr_tag_i),
    .wr_pfn_e_i (wr_pfn_even_i),
    .wr_val_e_i (wr_val_even_i),
    .wr_pfn_o_i (wr_pfn_odd_i),
    .wr_val_o_i (wr_val_odd_i),
    .tag_o      (tag_q),
    .pfn_e_o    (pfn_e_q),
    .pfn_o_o    (pfn_o_q),
    .val_e_o    (val_e_q),
    .val_o_o    (val_o_q)
  );

  pair_tlb_cam #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_cam (
    .look_tag_i (look_tag),
    .look_odd_i (look_odd),
    .tag_i      (tag_q),
    .val_e_i    (val_e_q),
    .val_o_i    (val_o_q),
    .match_o    (match),
    .half_ok_o  (half_ok)
  );

  pair_tlb_pick #(.SLOTS(SLOTS)) u_pick (
    .req_i (match),
    .idx_o (win_idx),
    .any_o (win_any)
  );

  assign hit_raw = win_any && half_ok[win_idx];
  assign pfn_sel = look_odd ? pfn_o_q[win_idx] : pfn_e_q[win_idx];

  assign lk_hit_o   = lk_req_i && hit_raw;
  assign lk_miss_o  = lk_req_i && !hit_raw;
  assign lk_paddr_o = lk_hit_o ? {pfn_sel, lk_vaddr_i[OFF_W-1:0]} : '0;
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int unsigned SLOTS = 64,
  parameter int unsigned VA_W  = 40,
  parameter int unsigned PA_W  = 40,
  parameter int unsigned OFF_W = 14
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     flush_i,
  input logic                     lk_req_i,
  input logic [VA_W-1:0]          lk_vaddr_i,
  input logic                     lk_hit_o,
  input logic                     lk_miss_o,
  input logic [PA_W-1:0]          lk_paddr_o,
  input logic                     wr_en_i,
  input logic [$clog2(SLOTS)-1:0] wr_idx_i,
  input logic [VA_W-OFF_W-2:0]    wr_tag_i,
  input logic                     wr_val_even_i,
  input logic                     wr_val_odd_i
);
  a_r2_hit_miss_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o));

  a_r2_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_paddr_o[OFF_W-1:0] == lk_vaddr_i[OFF_W-1:0]);

  a_r3_miss_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_miss_o |-> lk_paddr_o == '0);

  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |-> (!lk_hit_o && !lk_miss_o));

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> !lk_hit_o);

  // slot 0 just written with both halves valid always wins its tag
  a_r6_slot0_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && !flush_i && wr_val_even_i && wr_val_odd_i && wr_idx_i == '0)
     && lk_req_i && lk_vaddr_i[VA_W-1:OFF_W+1] == $past(wr_tag_i)) |-> lk_hit_o);
endmodule

bind pair_tlb pair_tlb_chk #(.SLOTS(SLOTS), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .lk_req_i      (lk_req_i),
  .lk_vaddr_i    (lk_vaddr_i),
  .lk_hit_o      (lk_hit_o),
  .lk_miss_o     (lk_miss_o),
  .lk_paddr_o    (lk_paddr_o),
  .wr_en_i       (wr_en_i),
  .wr_idx_i      (wr_idx_i),
  .wr_tag_i      (wr_tag_i),
  .wr_val_even_i (wr_val_even_i),
  .wr_val_odd_i  (wr_val_odd_i)
);

// File: tb/pair_tlb_bench.sv
`timescale 1ns/1ps
module pair_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req = 1'b0;
  logic [39:0] va = '0;
  logic        hit, miss;
  logic [39:0] pa;
  logic        wen = 1'b0;
  logic [5:0]  widx = '0;
  logic [24:0] wtag = '0;
  logic [25:0] wpe = '0, wpo = '0;
  logic        wve = 1'b0, wvo = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [24:0] m_tag [64];
  logic [25:0] m_pe  [64];
  logic [25:0] m_po  [64];
  logic        m_ve  [64];
  logic        m_vo  [64];
  logic [24:0] pool  [4];

  always #2.5 clk = ~clk;

  pair_tlb u_pair_tlb (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .lk_req_i(req), .lk_vaddr_i(va),
    .lk_hit_o(hit), .lk_miss_o(miss), .lk_paddr_o(pa),
    .wr_en_i(wen), .wr_idx_i(widx), .wr_tag_i(wtag),
    .wr_pfn_even_i(wpe), .wr_val_even_i(wve),
    .wr_pfn_odd_i(wpo), .wr_val_odd_i(wvo)
  );

  function automatic logic [41:0] ref_lk(input logic r, input logic [39:0] a);
    logic [24:0] t = a[39:15];
    logic        odd = a[14];
    logic        found = 1'b0;
    logic        hv;
    int          w = 0;
    for (int i = 0; i < 64; i++)
      if (!found && m_tag[i] == t && (m_ve[i] || m_vo[i])) begin
        found = 1'b1;
        w = i;
      end
    hv = found && (odd ? m_vo[w] : m_ve[w]);
    if (r && hv) return {1'b1, 1'b0, (odd ? m_po[w] : m_pe[w]), a[13:0]};
    return {1'b0, r, 40'h0};
  endfunction

  task automatic chk(input string rq, input logic [41:0] act, input logic [41:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic look(input string rq, input logic r, input logic [39:0] a);
    @(negedge clk);
    req = r;
    va  = a;
    #1 chk(rq, {hit, miss, pa}, ref_lk(r, a));
  endtask

  task automatic model_wr();
    m_tag[widx] = wtag; m_pe[widx] = wpe; m_po[widx] = wpo;
    m_ve[widx] = wve;   m_vo[widx] = wvo;
  endtask

  task automatic set_wr(input logic [5:0] i, input logic [24:0] t, input logic [25:0] pe,
                        input logic ve, input logic [25:0] po, input logic vo);
    wen = 1'b1; widx = i; wtag = t; wpe = pe; wve = ve; wpo = po; wvo = vo;
  endtask

  task automatic wr(input logic [5:0] i, input logic [24:0] t, input logic [25:0] pe,
                    input logic ve, input logic [25:0] po, input logic vo);
    @(negedge clk);
    set_wr(i, t, pe, ve, po, vo);
    @(negedge clk);
    wen = 1'b0;
    model_wr();
  endtask

  task automatic model_flush();
    for (int i = 0; i < 64; i++) begin m_ve[i] = 1'b0; m_vo[i] = 1'b0; end
  endtask

  function automatic logic [39:0] mk_va(input logic [24:0] t, input logic odd, input logic [13:0] off);
    return {t, odd, off};
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 64; i++) begin
      m_tag[i] = '0; m_pe[i] = '0; m_po[i] = '0; m_ve[i] = 1'b0; m_vo[i] = 1'b0;
    end
    for (int i = 0; i < 4; i++) pool[i] = 25'($urandom);

    // R10: reset state, all lookups miss
    look("R10 reset miss", 1'b1, 40'h12_3456_789A);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    look("R10 after reset miss", 1'b1, 40'h00_0000_0000);
    look("R4 idle no outputs", 1'b0, 40'hFF_FFFF_FFFF);

    // R1 R2: both halves of a pair
    wr(6'd5, 25'h0AB_CDE, 26'h123_4567, 1'b1, 26'h2AA_5555, 1'b1);
    look("R2 R1 even half", 1'b1, mk_va(25'h0AB_CDE, 1'b0, 14'h1234));
    look("R2 R1 odd half",  1'b1, mk_va(25'h0AB_CDE, 1'b1, 14'h3FFF));
    look("R4 idle with match", 1'b0, mk_va(25'h0AB_CDE, 1'b1, 14'h0001));
    look("R3 other tag miss", 1'b1, mk_va(25'h0AB_CDF, 1'b0, 14'h0));
    chk("R3 miss flag", {hit, miss}, 42'b01);

    // R5 R6: lower slot has invalid odd half, upper slot fully valid
    wr(6'd10, 25'h155_5555, 26'h3C3_C3C3, 1'b1, 26'h0F0_F0F0, 1'b1);
    wr(6'd3,  25'h155_5555, 26'h111_1111, 1'b1, 26'h222_2222, 1'b0);
    look("R6 low index even", 1'b1, mk_va(25'h155_5555, 1'b0, 14'h0ABC));
    chk("R6 low index frame", 42'(pa[39:14]), 42'(26'h111_1111));
    look("R5 invalid half misses", 1'b1, mk_va(25'h155_5555, 1'b1, 14'h0ABC));
    chk("R5 miss flag", {hit, miss}, 42'b01);
    // R6: empty lower slot stops competing
    wr(6'd3, 25'h155_5555, 26'h0, 1'b0, 26'h0, 1'b0);
    look("R6 empty slot skipped", 1'b1, mk_va(25'h155_5555, 1'b1, 14'h0ABC));
    chk("R6 upper frame", 42'(pa[39:14]), 42'(26'h0F0_F0F0));

    // R7: same-cycle write invisible, next cycle visible
    @(negedge clk);
    set_wr(6'd20, 25'h0777_777, 26'h0BE_EF00, 1'b1, 26'h0CA_FE00, 1'b1);
    req = 1'b1; va = mk_va(25'h0777_777, 1'b1, 14'h0042);
    #1 chk("R7 old contents in write cycle", {hit, miss, pa}, ref_lk(1'b1, va));
    chk("R7 still miss", {hit, miss}, 42'b01);
    @(negedge clk);
    wen = 1'b0;
    model_wr();
    #1 chk("R7 new contents next cycle", {hit, miss, pa}, ref_lk(1'b1, va));
    chk("R7 hit", {hit, miss}, 42'b10);

    // R8: overwrite replaces everything
    wr(6'd20, 25'h0888_888, 26'h001_0001, 1'b0, 26'h002_0002, 1'b1);
    look("R8 old tag gone", 1'b1, mk_va(25'h0777_777, 1'b1, 14'h0042));
    look("R8 new even invalid", 1'b1, mk_va(25'h0888_888, 1'b0, 14'h0042));
    look("R8 new odd frame", 1'b1, mk_va(25'h0888_888, 1'b1, 14'h0042));

    // R9: flush with simultaneous write, write dropped
    @(negedge clk);
    flush = 1'b1;
    set_wr(6'd30, 25'h0999_999, 26'h3FF_FFFF, 1'b1, 26'h3FF_FFFE, 1'b1);
    @(negedge clk);
    flush = 1'b0; wen = 1'b0;
    model_flush();
    look("R9 flushed pair", 1'b1, mk_va(25'h0AB_CDE, 1'b0, 14'h1234));
    look("R9 write dropped", 1'b1, mk_va(25'h0999_999, 1'b0, 14'h0));
    chk("R9 miss flag", {hit, miss}, 42'b01);

    // R11: fill every index, translate each
    for (int i = 0; i < 64; i++)
      wr(6'(i), 25'h100_0000 + 25'(i), 26'h200_0000 + 26'(i), 1'b1, 26'h300_0000 + 26'(i), 1'b1);
    for (int i = 0; i < 64; i++)
      look("R11 every index", 1'b1, mk_va(25'h100_0000 + 25'(i), 1'(i), 14'(i * 97)));
    look("R11 last index", 1'b1, mk_va(25'h100_003F, 1'b1, 14'h3FFF));
    chk("R11 last frame", 42'(pa[39:14]), 42'(26'h300_003F));

    // random mix over a small tag pool: R2 R3 R5 R6
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 2) == 0)
        wr(6'($urandom), pool[$urandom_range(0, 3)], 26'($urandom), 1'($urandom),
           26'($urandom), 1'($urandom));
      else
        look("R2 R3 R5 R6 random", 1'($urandom_range(0, 7) != 0),
             mk_va(pool[$urandom_range(0, 3)], 1'($urandom), 14'($urandom)));
    end

    @(negedge clk);
    req = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule